// File: doc/BRIEF.md
# Masked Multi-Address I2C Slave Matcher

This block decides whether an I2C address phase is addressed to this device. It takes the received first address byte, and the second byte when the first byte carries the 10-bit prefix. It compares them against four programmable 7-bit slot addresses and one 10-bit extended address. Every slot has its own care mask. The block also detects the general call address when general call is enabled. On a strobe it registers which kind of match occurred, which slot matched, the ACK decision, the read/write bit and the raw received byte.

A slave controller uses it as follows. The controller strobes in the address bytes it has shifted off the wire. It then drives SDA from the registered ACK decision. Software reads back the captured byte to learn which address caused the match. The match flags and the ACK decision clear by themselves when the controller signals the next data-byte transfer.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, all match flags, the ACK decision, the matched slot index, the captured byte and the read/write output are 0.
- R2: Slot i holds its configuration as {address[6:0], gc_enable} in bits [8i+7:8i]. Received bits [7:1] of the first byte are compared against that address. A match sets the 7-bit match flag one clock after the strobe, and the slot index output gives the slot number. The index reads 0 whenever the 7-bit flag is clear.
- R3: A slot mask bit of 1 makes the corresponding address bit significant. A mask bit of 0 makes that bit don't-care.
- R4: When several slots match, the lowest-numbered matching slot is reported. Only one of the three match flags is ever set.
- R5: A first byte with bits [7:1] all zero sets the general call flag only when at least one slot has its gc_enable bit set and no slot matches. Masks are never applied to this comparison.
- R6: A first byte whose bits [7:3] equal 11110 is treated as a 10-bit address. The 10-bit value is {byte0[2:1], byte1[7:0]}. It is compared against the extended address under the extended mask and sets the 10-bit match flag. The 7-bit slots are not consulted for such a byte.
- R7: With the assert-acknowledge input low at the strobe, no flag is set and the ACK decision is 0.
- R8: The ACK decision is 1 exactly when one of the match flags is set.
- R9: A data-transfer event without a strobe clears all flags, the slot index and the ACK decision on the next clock. If a strobe arrives in the same cycle, the strobe wins.
- R10: Every strobe captures the first byte, matched or not, on the captured-byte output, with its bit 0 on the read/write output. Both hold until the next strobe and are unaffected by data-transfer events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | Strobe: address bytes are valid |
| addr_byte0_i | input | 8 | First address byte, bit 0 is R/W |
| addr_byte1_i | input | 8 | Second address byte (10-bit mode) |
| slot_cfg_i | input | 32 | Four slot configs {addr[6:0], gc_en} |
| slot_mask_i | input | 28 | Four 7-bit care masks, slot i at [7i+6:7i] |
| ext_addr_i | input | 10 | Extended 10-bit address |
| ext_mask_i | input | 10 | Extended address care mask |
| aa_i | input | 1 | Assert-acknowledge enable |
| data_xfer_i | input | 1 | Next data byte transferred event |
| match7_o | output | 1 | 7-bit slot matched |
| match10_o | output | 1 | 10-bit address matched |
| gen_call_o | output | 1 | General call matched |
| slot_o | output | 2 | Index of matched slot |
| ack_o | output | 1 | ACK decision |
| rw_o | output | 1 | Captured read/write bit |
| rx_addr_o | output | 8 | Captured first address byte |

## Verification
All results are registered once, so every flag, the slot index, the ACK decision and the captured byte are due on the first rising edge after the strobe cycle. A data-transfer clear is likewise due one edge after the event. The bench drives inputs at the falling edge and holds each strobe for exactly one cycle. It then samples at the next falling edge, half a period after the updating edge, so each check reads the value that is due. The clear and the strobe-precedence checks are timed the same way.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;
  localparam int ADDR7_W  = 7;
  localparam int ADDR10_W = 10;
  localparam int CFG_W    = ADDR7_W + 1;
  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

  typedef struct packed {
    logic m7;
    logic m10;
    logic gc;
  } match_flags_t;
endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  // mask bit 1 = significant
  assign hit_o = ~|((rx_i ^ addr_i) & mask_i);
endmodule

// File: rtl/i2c_slot_prio.sv
module i2c_slot_prio #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |hits_i;

  // R4: reported slot really hit, and no lower slot hit
  always_comb begin
    if (any_o) begin
      p_sel_hit_r4: assert (hits_i[idx_o]);
      p_sel_lowest_r4: assert ((hits_i & ((N'(1) << idx_o) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_match_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           addr_valid_i,
  input  logic [7:0]                     addr_byte0_i,
  input  logic [7:0]                     addr_byte1_i,
  input  logic [NUM_SLOTS*CFG_W-1:0]     slot_cfg_i,
  input  logic [NUM_SLOTS*ADDR7_W-1:0]   slot_mask_i,
  input  logic [ADDR10_W-1:0]            ext_addr_i,
  input  logic [ADDR10_W-1:0]            ext_mask_i,
  input  logic                           aa_i,
  input  logic                           data_xfer_i,
  output logic                           match7_o,
  output logic                           match10_o,
  output logic                           gen_call_o,
  output logic [IDX_W-1:0]               slot_o,
  output logic                           ack_o,
  output logic                           rw_o,
  output logic [7:0]                     rx_addr_o
);
  logic [ADDR7_W-1:0]   rx7;
  logic [ADDR10_W-1:0]  rx10;
  logic                 is_ten;
  logic [NUM_SLOTS-1:0] cmp_hits;
  logic [NUM_SLOTS-1:0] slot_hits;
  logic [NUM_SLOTS-1:0] gc_en_vec;
  logic                 any_slot;
  logic [IDX_W-1:0]     sel_idx;
  logic                 ext_hit_raw;
  match_flags_t         nxt;
  match_flags_t         flags_q;

  assign rx7    = addr_byte0_i[7:1];
  assign rx10   = {addr_byte0_i[2:1], addr_byte1_i};
  assign is_ten = (addr_byte0_i[7:3] == TEN_BIT_PREFIX);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    i2c_addr_cmp #(.W(ADDR7_W)) u_cmp (
      .rx_i   (rx7),
      .addr_i (slot_cfg_i[g*CFG_W+1 +: ADDR7_W]),
      .mask_i (slot_mask_i[g*ADDR7_W +: ADDR7_W]),
      .hit_o  (cmp_hits[g])
    );
    assign gc_en_vec[g] = slot_cfg_i[g*CFG_W];
  end

  // 10-bit first bytes bypass the 7-bit slots
  assign slot_hits = is_ten ? '0 : cmp_hits;

  i2c_slot_prio #(.N(NUM_SLOTS)) u_prio (
    .hits_i (slot_hits),
    .any_o  (any_slot),
    .idx_o  (sel_idx)
  );

  i2c_addr_cmp #(.W(ADDR10_W)) u_ext_cmp (
    .rx_i   (rx10),
    .addr_i (ext_addr_i),
    .mask_i (ext_mask_i),
    .hit_o  (ext_hit_raw)
  );

  always_comb begin
    nxt.m7  = aa_i & any_slot;
    nxt.m10 = aa_i & is_ten & ext_hit_raw;
    // general call: exact zero, unmasked, only if no slot claims it
    nxt.gc  = aa_i & (rx7 == '0) & (|gc_en_vec) & ~any_slot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      slot_o    <= '0;
      ack_o     <= 1'b0;
      rw_o      <= 1'b0;
      rx_addr_o <= '0;
    end else if (addr_valid_i) begin
      flags_q   <= nxt;
      slot_o    <= nxt.m7 ? sel_idx : '0;
      ack_o     <= nxt.m7 | nxt.m10 | nxt.gc;
      rw_o      <= addr_byte0_i[0];
      rx_addr_o <= addr_byte0_i;
    end else if (data_xfer_i) begin
      flags_q <= '0;
      slot_o  <= '0;
      ack_o   <= 1'b0;
    end
  end

  assign match7_o   = flags_q.m7;
  assign match10_o  = flags_q.m10;
  assign gen_call_o = flags_q.gc;

  p_slot_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match7_o |-> slot_o == '0);
  p_one_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({match7_o, match10_o, gen_call_o}));
  p_gc_zero_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> rx_addr_o[7:1] == '0);
  p_ten_prefix_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match10_o |-> rx_addr_o[7:3] == TEN_BIT_PREFIX);
  p_no_aa_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i && !aa_i |=> !ack_o && !match7_o && !match10_o && !gen_call_o);
  p_ack_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == (match7_o | match10_o | gen_call_o));
  p_xfer_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_xfer_i && !addr_valid_i |=> !ack_o && !match7_o && !match10_o && !gen_call_o);
  p_capture_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> $stable(rx_addr_o) && $stable(rw_o));
  p_rw_bit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_o == rx_addr_o[0]);
endmodule

// File: tb/i2c_addr_matcher_tb_top.sv
module i2c_addr_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  b0 = '0;
  logic [7:0]  b1 = '0;
  logic [31:0] cfg;
  logic [27:0] msk;
  logic [9:0]  ext_a;
  logic [9:0]  ext_m;
  logic        aa = 1'b1;
  logic        xfer = 1'b0;
  logic        m7, m10, gc, ack, rw;
  logic [1:0]  slot;
  logic [7:0]  rx_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_matcher dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_valid_i(valid),
    .addr_byte0_i(b0), .addr_byte1_i(b1),
    .slot_cfg_i(cfg), .slot_mask_i(msk),
    .ext_addr_i(ext_a), .ext_mask_i(ext_m),
    .aa_i(aa), .data_xfer_i(xfer),
    .match7_o(m7), .match10_o(m10), .gen_call_o(gc),
    .slot_o(slot), .ack_o(ack), .rw_o(rw), .rx_addr_o(rx_addr)
  );

  // {aa, byte0, byte1, m7, m10, gc, slot}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'hA0, 8'h00, 3'b100, 2'd0},  // R2 slot0 write
    {1'b1, 8'hA1, 8'h00, 3'b100, 2'd0},  // R2 slot0 read
    {1'b1, 8'h42, 8'h00, 3'b100, 2'd1},  // R3 masked slot1
    {1'b1, 8'h46, 8'h00, 3'b100, 2'd1},  // R4 slot1 and slot2 hit
    {1'b1, 8'hDE, 8'h00, 3'b100, 2'd3},  // R3 slot3 wide mask
    {1'b1, 8'hA2, 8'h00, 3'b000, 2'd0},  // R2 no match
    {1'b1, 8'h00, 8'h00, 3'b001, 2'd0},  // R5 general call
    {1'b1, 8'hF4, 8'hA5, 3'b010, 2'd0},  // R6 10-bit hit
    {1'b1, 8'hF4, 8'hA4, 3'b000, 2'd0},  // R6 low bit differs
    {1'b1, 8'hF2, 8'hA5, 3'b000, 2'd0},  // R6 upper bits differ
    {1'b0, 8'hA0, 8'h00, 3'b000, 2'd0}   // R7 no AA
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic a, input logic [7:0] x0, input logic [7:0] x1, input logic xf);
    @(negedge clk);
    aa = a; b0 = x0; b1 = x1; valid = 1'b1; xfer = xf;
    @(negedge clk);
    valid = 1'b0; xfer = 1'b0;
  endtask

  task automatic check_flags(input string req, input logic [2:0] ef, input logic [1:0] es);
    check(req, {29'd0, m7, m10, gc}, {29'd0, ef});
    check(req, {30'd0, slot}, {30'd0, es});
    check({req, " R8 ack"}, {31'd0, ack}, {31'd0, |ef});
  endtask

  initial begin
    cfg   = {8'hD0, 8'h46, 8'h45, 8'hA0};  // slot3..slot0
    msk   = {7'h70, 7'h7F, 7'h7C, 7'h7F};
    ext_a = 10'h2A5;
    ext_m = 10'h3FF;
    #5;
    check("R1 flags", {29'd0, m7, m10, gc}, 0);
    check("R1 ack", {31'd0, ack}, 0);
    check("R1 capture", {23'd0, rw, rx_addr}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 slot after release", {30'd0, slot}, 0);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][21], VEC[i][20:13], VEC[i][12:5], 1'b0);
      check_flags($sformatf("vec%0d", i), VEC[i][4:2], VEC[i][1:0]);
      check("R10 capture", {24'd0, rx_addr}, {24'd0, VEC[i][20:13]});
      check("R10 rw", {31'd0, rw}, {31'd0, VEC[i][13]});
    end

    // R9: transfer event clears flags, keeps capture
    strobe(1'b1, 8'hDF, 8'h00, 1'b0);
    check_flags("R2 slot3 before clear", 3'b100, 2'd3);
    @(negedge clk); xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
    check_flags("R9 cleared", 3'b000, 2'd0);
    check("R10 capture after xfer", {23'd0, rw, rx_addr}, {23'd0, 1'b1, 8'hDF});

    // R9: strobe wins over simultaneous transfer
    strobe(1'b1, 8'hF4, 8'hA5, 1'b1);
    check_flags("R9 strobe precedence", 3'b010, 2'd0);

    // R10: no-match strobe still captures, clears previous flags
    strobe(1'b1, 8'h10, 8'h00, 1'b0);
    check_flags("R10 nomatch flags", 3'b000, 2'd0);
    check("R10 nomatch capture", {24'd0, rx_addr}, 32'h10);

    // R5: general call disabled everywhere
    cfg[8] = 1'b0;
    strobe(1'b1, 8'h01, 8'h00, 1'b0);
    check_flags("R5 gc disabled", 3'b000, 2'd0);

    // R5: slot with all-zero mask claims 0x00 before general call
    cfg[8] = 1'b1;
    msk[27:21] = 7'h00;
    strobe(1'b1, 8'h00, 8'h00, 1'b0);
    check_flags("R5 slot beats gc", 3'b100, 2'd3);
    msk[27:21] = 7'h70;

    // R6: extended mask low nibble don't-care
    ext_m = 10'h3F0;
    strobe(1'b1, 8'hF4, 8'hAF, 1'b0);
    check_flags("R6 ext masked", 3'b010, 2'd0);

    // R6: 10-bit prefix bypasses slots even if a slot would match
    msk[27:21] = 7'h00;
    strobe(1'b1, 8'hF6, 8'h00, 1'b0);
    check_flags("R6 prefix bypass", 3'b000, 2'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule